// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block arbitrates eight interrupt request lines for a single interrupt controller. Each line is captured into a request register. A per-line trigger-mode bit chooses the capture rule. In edge mode, a bit is latched on a low-to-high transition. In level mode, the bit simply tracks the input. A mask register removes lines from arbitration. An in-service register records the lines that have been acknowledged and not yet retired.

Ranking is circular. A rotation offset names the line that currently has the highest priority, and priority falls as the line number rises, wrapping modulo eight. An unmasked request is presented, as a pending flag and a line number, only when it outranks every line in service. An optional nesting mode lets the cascade line be presented again while it is already in service.

The surrounding controller drives the configuration writes and the acknowledge and end-of-service strobes. End of service comes in two forms, highest-ranked or named line, and either form can also rotate priority.

Top module: `irq_rank_resolver`

## Requirements
- R1: After reset, the request, in-service, mask, trigger-mode and rotation registers and the nesting flag are all zero, and `irq_pending` is low.
- R2: For a line whose trigger bit is 0 (edge), the request bit sets at the clock edge after the input is seen high when it was low at the previous edge. A steady high input does not set it again. A low input does not clear it.
- R3: For a line whose trigger bit is 1 (level), the request bit takes the input value at every clock edge, and an acknowledge leaves it unchanged.
- R4: Lines rank from line `rot` (highest) upward modulo 8. `irq_line` is the highest-ranked line among the candidates.
- R5: Candidates are the request bits whose mask bit is 0. A mask bit of 1 keeps that line from being pending.
- R6: `irq_pending` is 1 only when the best candidate rank is strictly better than the best rank among in-service bits. An equal rank does not raise it.
- R7: When the nesting flag is 1 and the instance is a master, the in-service bit of the cascade line (line 2) is ignored when the in-service rank is computed.
- R8: An acknowledge while `irq_pending` is 1 sets the in-service bit of `irq_line` and clears that line's request bit if the line is in edge mode. An acknowledge while `irq_pending` is 0 changes nothing.
- R9: A non-specific end of service (`eoi`=1, `eoi_specific`=0) clears the highest-ranked in-service bit. With `eoi_rotate`=1 it also sets `rot` to that line plus 1, modulo 8.
- R10: A specific end of service (`eoi_specific`=1) clears in-service bit `eoi_line`. With `eoi_rotate`=1 it sets `rot` to `eoi_line`+1, modulo 8. A rotation write (`rot_we`) in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Raw request inputs, one per line |
| trig_we | input | 1 | Write strobe for the trigger-mode register |
| trig_wdata | input | 8 | Trigger modes: 1 = level, 0 = edge |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 | Mask bits: 1 = line blocked |
| rot_we | input | 1 | Write strobe for the rotation offset |
| rot_wdata | input | 3 | Line number that becomes highest priority |
| nest_we | input | 1 | Write strobe for the nesting flag |
| nest_wdata | input | 1 | Nesting flag value |
| ack | input | 1 | Acknowledge of the presented line |
| eoi | input | 1 | End-of-service strobe |
| eoi_specific | input | 1 | 1 = retire `eoi_line`; 0 = retire the highest-ranked in-service line |
| eoi_rotate | input | 1 | Rotate priority past the retired line |
| eoi_line | input | 3 | Line that a specific end of service retires |
| irq_pending | output | 1 | A candidate outranks everything in service |
| irq_line | output | 3 | Winning line number, valid while `irq_pending` is 1 |
| req_vec | output | 8 | Request register |
| svc_vec | output | 8 | In-service register |

## Verification
Directed sequences separate the edge and level capture rules. One sequence holds an edge input high across an acknowledge and shows that it does not set again. Another drops a level input and shows that its request bit clears. Fixed-offset cases show that rotation changes the winner while the request pattern stays the same. Equal-rank cases show strict against non-strict comparison with the in-service register. Toggling the nesting flag with line 2 in service and requested again shows whether the cascade bit is excluded. A long random run follows, with random requests, masks, trigger modes, rotations and mixed acknowledge and end-of-service strobes. It is checked every cycle against a bench model, which catches wrong wrap-around in the ranking and wrong interaction between simultaneous strobes.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;
  localparam int NL = 8;
  localparam int LW = $clog2(NL);
  localparam int RW = LW + 1;

  typedef logic [NL-1:0] lvec_t;
  typedef logic [LW-1:0] lidx_t;
  typedef logic [RW-1:0] rank_t;

  localparam rank_t RANK_NONE = rank_t'(NL);

  // Distance from the rotation offset to the first set bit, or RANK_NONE
  function automatic rank_t rank_first(lvec_t v, lidx_t off);
    rank_t r;
    r = RANK_NONE;
    for (int k = NL - 1; k >= 0; k--) begin
      lidx_t idx;
      idx = off + lidx_t'(k);
      if (v[idx]) r = rank_t'(k);
    end
    return r;
  endfunction

  // Rank back to an absolute line number (wraps modulo NL)
  function automatic lidx_t line_of(rank_t r, lidx_t off);
    return r[LW-1:0] + off;
  endfunction

  function automatic lvec_t onehot(lidx_t idx);
    return lvec_t'(1) << idx;
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_rank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lvec_t irq_in,
  input  lvec_t trig_q,
  input  lvec_t edge_clr,
  output lvec_t req_q,
  output lvec_t rise
);
  lvec_t last_q;

  for (genvar i = 0; i < NL; i++) begin : g_line
    assign rise[i] = irq_in[i] & ~last_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[i]  <= 1'b0;
        last_q[i] <= 1'b0;
      end else begin
        last_q[i] <= irq_in[i];
        if (trig_q[i]) req_q[i] <= irq_in[i];
        else           req_q[i] <= rise[i] | (req_q[i] & ~edge_clr[i]);
      end
    end
  end

  // R2: a fresh rising edge on an edge-mode line leaves its request bit set
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & ~trig_q) != '0) |=> ((req_q & $past(rise & ~trig_q)) == $past(rise & ~trig_q)));

  // R3: level-mode request bits mirror the sampled input
  a_r3_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((req_q ^ $past(irq_in)) & $past(trig_q)) == '0));
endmodule

// File: rtl/irq_rank_scan.sv
module irq_rank_scan
  import irq_rank_pkg::*;
(
  input  lvec_t vec,
  input  lidx_t off,
  output rank_t rank,
  output lidx_t line
);
  assign rank = rank_first(vec, off);
  assign line = line_of(rank, off);
endmodule

// File: rtl/irq_service.sv
module irq_service
  import irq_rank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lvec_t set_vec,
  input  lvec_t clr_vec,
  input  logic  rot_load,
  input  lidx_t rot_data,
  input  logic  rot_step,
  input  lidx_t rot_step_val,
  output lvec_t svc_q,
  output lidx_t rot_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q <= '0;
      rot_q <= '0;
    end else begin
      svc_q <= (svc_q | set_vec) & ~clr_vec;
      if (rot_load)      rot_q <= rot_data;
      else if (rot_step) rot_q <= rot_step_val;
    end
  end

  // R8: an accepted acknowledge lands in the in-service register
  a_r8_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0 && clr_vec == '0) |=> ((svc_q & $past(set_vec)) == $past(set_vec)));

  // R9 and R10: retiring a set bit removes exactly one in-service bit
  a_r9_eoi_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & svc_q) != '0 && set_vec == '0 && $onehot0(clr_vec))
      |=> ($countones(svc_q) + 1 == $countones($past(svc_q))));
endmodule

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver
  import irq_rank_pkg::*;
#(
  parameter int  CASCADE_LINE = 2,
  parameter bit  IS_MASTER    = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic          trig_we,
  input  logic [NL-1:0] trig_wdata,
  input  logic          mask_we,
  input  logic [NL-1:0] mask_wdata,
  input  logic          rot_we,
  input  logic [LW-1:0] rot_wdata,
  input  logic          nest_we,
  input  logic          nest_wdata,
  input  logic          ack,
  input  logic          eoi,
  input  logic          eoi_specific,
  input  logic          eoi_rotate,
  input  logic [LW-1:0] eoi_line,
  output logic          irq_pending,
  output logic [LW-1:0] irq_line,
  output logic [NL-1:0] req_vec,
  output logic [NL-1:0] svc_vec
);
  localparam lvec_t CASC_BIT = lvec_t'(1) << CASCADE_LINE;

  lvec_t mask_q, trig_q, req_q, svc_q, rise;
  logic  nest_q;
  lidx_t rot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      trig_q <= '0;
      nest_q <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (trig_we) trig_q <= trig_wdata;
      if (nest_we) nest_q <= nest_wdata;
    end
  end

  // Named internal events
  lvec_t cand_vec, cur_vec, ack_vec, clr_vec, edge_clr;
  rank_t cand_rank, cur_rank, eoi_rank;
  lidx_t cand_line, eoi_top_line, eoi_target;
  logic  nest_skip, ack_fire, eoi_hit, rot_step;

  assign nest_skip = IS_MASTER && nest_q;
  assign cand_vec  = req_q & ~mask_q;
  assign cur_vec   = nest_skip ? (svc_q & ~CASC_BIT) : svc_q;

  irq_rank_scan u_cand (.vec(cand_vec), .off(rot_q), .rank(cand_rank), .line(cand_line));
  irq_rank_scan u_cur  (.vec(cur_vec),  .off(rot_q), .rank(cur_rank),  .line());
  irq_rank_scan u_eoi  (.vec(svc_q),    .off(rot_q), .rank(eoi_rank),  .line(eoi_top_line));

  assign irq_pending = cand_rank < cur_rank;
  assign irq_line    = cand_line;

  assign ack_fire = ack && irq_pending;
  assign ack_vec  = ack_fire ? onehot(cand_line) : '0;
  assign edge_clr = ack_vec & ~trig_q;

  assign eoi_target = eoi_specific ? eoi_line : eoi_top_line;
  assign eoi_hit    = eoi && (eoi_specific || eoi_rank != RANK_NONE);
  assign clr_vec    = eoi_hit ? onehot(eoi_target) : '0;
  assign rot_step   = eoi_hit && eoi_rotate;

  irq_capture u_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_q(trig_q),
    .edge_clr(edge_clr), .req_q(req_q), .rise(rise)
  );

  irq_service u_service (
    .clk(clk), .rst_n(rst_n), .set_vec(ack_vec), .clr_vec(clr_vec),
    .rot_load(rot_we), .rot_data(rot_wdata), .rot_step(rot_step),
    .rot_step_val(eoi_target + lidx_t'(1)), .svc_q(svc_q), .rot_q(rot_q)
  );

  assign req_vec = req_q;
  assign svc_vec = svc_q;

  // R5: the presented line is requested and unmasked
  a_r5_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (req_vec[irq_line] && !mask_q[irq_line]));

  // R6, R7: the winner is not in service unless it is the skipped cascade line
  a_r6_winner_not_served: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !(nest_skip && int'(irq_line) == CASCADE_LINE)) |-> !svc_vec[irq_line]);

  // R8: an acknowledge with nothing pending leaves the in-service register alone
  a_r8_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_pending && !eoi) |=> $stable(svc_vec));
endmodule

// File: tb/irq_rank_resolver_bench.sv
module irq_rank_resolver_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] irq_in = '0, trig_wdata = '0, mask_wdata = '0;
  logic trig_we = 0, mask_we = 0, rot_we = 0, nest_we = 0, nest_wdata = 0;
  logic ack = 0, eoi = 0, eoi_specific = 0, eoi_rotate = 0;
  logic [2:0] rot_wdata = '0, eoi_line = '0;
  logic irq_pending;
  logic [2:0] irq_line;
  logic [7:0] req_vec, svc_vec;

  int checks = 0, fails = 0;
  bit [7:0] m_req, m_last, m_svc, m_mask, m_trig;
  bit [2:0] m_rot;
  bit m_nest;

  always #4 clk = ~clk;

  irq_rank_resolver u_irq_rank_resolver (.*);

  function automatic int b_rank(bit [7:0] v, int off);
    int k = 0;
    while (k < 8 && !v[(off + k) % 8]) k++;
    return k;
  endfunction

  function automatic bit b_pend();
    bit [7:0] cur = m_nest ? (m_svc & 8'hFB) : m_svc;
    return b_rank(m_req & ~m_mask, m_rot) < b_rank(cur, m_rot);
  endfunction

  function automatic int b_line();
    return (b_rank(m_req & ~m_mask, m_rot) + m_rot) % 8;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit [7:0] ackv = 0, clrv = 0, rn;
    int er, tgt;
    bit hit;
    if (ack && b_pend()) ackv = 8'd1 << b_line();
    for (int i = 0; i < 8; i++)
      rn[i] = m_trig[i] ? irq_in[i] : ((irq_in[i] & !m_last[i]) | (m_req[i] & !ackv[i]));
    er  = b_rank(m_svc, m_rot);
    tgt = eoi_specific ? int'(eoi_line) : (er + m_rot) % 8;
    hit = eoi && (eoi_specific || er < 8);
    if (hit) clrv = 8'd1 << tgt;
    @(posedge clk);
    #2;
    m_req = rn; m_last = irq_in;
    m_svc = (m_svc | ackv) & ~clrv;
    if (rot_we) m_rot = rot_wdata;
    else if (hit && eoi_rotate) m_rot = 3'((tgt + 1) % 8);
    if (mask_we) m_mask = mask_wdata;
    if (trig_we) m_trig = trig_wdata;
    if (nest_we) m_nest = nest_wdata;
    chk("R2 R3 request register", req_vec, m_req);
    chk("R8 R9 R10 in-service register", svc_vec, m_svc);
    chk("R4 R5 R6 R7 pending", irq_pending, b_pend());
    if (b_pend()) chk("R4 line", irq_line, b_line());
    {trig_we, mask_we, rot_we, nest_we, ack, eoi, eoi_specific, eoi_rotate} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    chk("R1 pending", irq_pending, 0);
    chk("R1 req", req_vec, 0);
    chk("R1 svc", svc_vec, 0);
    // R2 edge capture, R8 acknowledge
    irq_in = 8'h08; step();
    chk("R2 set on rise", req_vec, 8'h08);
    chk("R4 line 3", irq_line, 3);
    ack = 1; step();
    chk("R8 svc set", svc_vec, 8'h08);
    chk("R8 edge request cleared", req_vec, 8'h00);
    step();
    chk("R2 no retrigger while high", req_vec, 8'h00);
    irq_in = 0; step(); irq_in = 8'h08; step();
    chk("R6 equal rank not pending", irq_pending, 0);
    eoi = 1; step();
    chk("R9 highest in-service retired", svc_vec, 8'h00);
    chk("R9 pending again", irq_pending, 1);
    ack = 1; step();
    eoi = 1; eoi_rotate = 1; step();
    irq_in = 0; step(); irq_in = 8'h42; step();
    chk("R9 rotation to 4 picks line 6", irq_line, 6);
    mask_we = 1; mask_wdata = 8'h40; step();
    chk("R5 masked line skipped", irq_line, 1);
    mask_we = 1; mask_wdata = 8'hFF; step();
    chk("R5 all masked", irq_pending, 0);
    mask_we = 1; mask_wdata = 8'h00; step();
    // R3 level mode
    trig_we = 1; trig_wdata = 8'h20; step();
    irq_in = 8'h62; step();
    chk("R3 level high", req_vec & 8'h20, 8'h20);
    irq_in = 8'h42; step();
    chk("R3 level low clears", req_vec & 8'h20, 8'h00);
    // R10 specific end of service with rotation
    ack = 1; step();
    chk("R8 line 6 in service", svc_vec, 8'h40);
    eoi = 1; eoi_specific = 1; eoi_line = 3'd6; eoi_rotate = 1; step();
    chk("R10 specific retire", svc_vec, 8'h00);
    irq_in = 8'h43; step();
    chk("R10 rotation to 7 picks line 0", irq_line, 0);
    // R7 nesting on the cascade line
    rot_we = 1; rot_wdata = 0; nest_we = 1; nest_wdata = 1;
    mask_we = 1; mask_wdata = 8'hFB; irq_in = 0; step();
    irq_in = 8'h04; step();
    ack = 1; step();
    irq_in = 0; step(); irq_in = 8'h04; step();
    chk("R7 cascade re-presented", irq_pending, 1);
    chk("R7 cascade line", irq_line, 2);
    nest_we = 1; nest_wdata = 0; step();
    chk("R7 without nesting blocked", irq_pending, 0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      irq_in = 8'($urandom);
      ack = ($urandom % 3) == 0;
      eoi = ($urandom % 5) == 0;
      eoi_specific = $urandom % 2;
      eoi_rotate = ($urandom % 4) == 0;
      eoi_line = 3'($urandom);
      if (($urandom % 16) == 0) begin mask_we = 1; mask_wdata = 8'($urandom) & 8'($urandom); end
      if (($urandom % 16) == 0) begin trig_we = 1; trig_wdata = 8'($urandom); end
      if (($urandom % 16) == 0) begin rot_we = 1; rot_wdata = 3'($urandom); end
      if (($urandom % 32) == 0) begin nest_we = 1; nest_wdata = $urandom % 2; end
      step();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule